// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt output to a host processor. The host reaches it over a byte bus with one address bit. With the address bit low the bus selects the command port, and with it high the bus selects the data port. A command write with bit 4 set begins a setup sequence. Up to three data writes then follow. They load the vector base, consume a cascade configuration byte, and optionally choose automatic end-of-interrupt. After setup, data-port accesses reach the mask register. Command writes then issue end-of-interrupt commands or choose which status register a command-port read returns.

When the host answers the interrupt with a one-cycle acknowledge strobe, the block selects the winning line, which is the lowest-numbered eligible line. It marks that line as in service unless automatic end-of-interrupt is on. From the next cycle it drives an 8-bit vector built from the base and the line number. An acknowledge with nothing eligible produces the line-7 vector and marks no line. Software uses this to recognise a spurious interrupt. Each line can be sensed on a rising edge or on its level, chosen by a per-line input.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the interrupt output is low, a data-port read returns 0xFF (all lines masked), a command-port read returns the pending-request register as 0x00, and the vector output is 0x00.
- R2: A command-port write with bit 4 set clears the mask to 0x00, selects pending-request reads, and starts setup. The next data writes are taken as the vector base, then the cascade byte, then the mode byte if bit 0 of the first write was set. After the last of these, data writes reach the mask.
- R3: The vector output, valid from the cycle after an acknowledge, holds bits 7:3 of the base byte in its bits 7:3 and the serviced line number in bits 2:0.
- R4: Line 0 has the highest priority and line 7 the lowest. A line in service blocks the interrupt output for itself and for every lower-priority line. A higher-priority request still raises the output.
- R5: A line with its trigger-mode input low latches a request on a rising edge. That request clears at acknowledge or when the input falls. A line with its trigger-mode input high shows its input level directly in the pending-request register.
- R6: A set mask bit keeps its line from raising the interrupt output, but the line still appears in the pending-request register.
- R7: A command write of 0x60+n, with n from 0 to 7, clears in-service bit n and leaves the other in-service bits unchanged.
- R8: A command write of 0x20 clears only the lowest-numbered set in-service bit.
- R9: When bit 1 of the mode byte is set, an acknowledge leaves the in-service register unchanged. When the mode byte is skipped, this mode is off.
- R10: A command write of 0x0B makes command-port reads return the in-service register. A write of 0x0A makes them return the pending-request register. The choice persists across other accesses.
- R11: An acknowledge while the interrupt output is low returns the base with 7 in bits 2:0 and sets no in-service bit.
- R12: In normal operation a data-port read returns exactly the last mask value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_a0 | input | 1 | Port select: 0 command, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the port selected by bus_a0 (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line sense: 1 level, 0 rising edge |
| ack | input | 1 | One-cycle interrupt acknowledge |
| int_out | output | 1 | Interrupt request to the host |
| vector | output | 8 | Vector of the last acknowledge |

## Verification
Several properties assume that the host does not write to the command port in the same cycle as an acknowledge. Under that assumption the change in the in-service register comes from the acknowledge alone. The bench keeps the two apart: bus writes and acknowledge pulses come from separate tasks that each take whole cycles and never overlap. It also drives the request lines and the trigger-mode inputs only between clock edges, away from the active edge.

// File: rtl/irq_ctrl8.sv
`timescale 1ns/1ps
module irq_ctrl8 #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_a0,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] irq_in,
  input  logic [DW-1:0] trig_level,
  input  logic          ack,
  output logic          int_out,
  output logic [DW-1:0] vector
);
  localparam int LINES = DW;
  localparam int IW = $clog2(LINES);

  typedef enum logic [1:0] {RUN, W_BASE, W_CASC, W_MODE} st_t;
  st_t st;

  logic [LINES-1:0] irq_q, edge_irr, irr, isr, imr, pend, allowed, req, req_bit, isr_bit;
  logic [LINES-1:0] isr_clr, isr_set;
  logic [DW-IW-1:0] base;
  logic [IW-1:0]    req_idx;
  logic             need_mode, aeoi, rsel;

  wire run     = (st == RUN);
  wire cmd_wr  = bus_wr & ~bus_a0;
  wire dat_wr  = bus_wr & bus_a0;
  wire init_wr = cmd_wr & bus_wdata[4];
  wire ocw2    = run & cmd_wr & ~bus_wdata[4] & ~bus_wdata[3];
  wire eoi_sp  = ocw2 & (bus_wdata[7:5] == 3'b011);
  wire eoi_ns  = ocw2 & (bus_wdata[7:5] == 3'b001);
  wire rd_sel  = run & cmd_wr & ~bus_wdata[4] & bus_wdata[3] & bus_wdata[1];
  wire take    = ack & int_out;

  assign irr     = (trig_level & irq_in) | (~trig_level & edge_irr);
  assign pend    = irr & ~imr;
  assign req     = run ? (pend & allowed) : '0;
  assign int_out = |req;
  assign req_bit = req & (~req + 1'b1);
  assign isr_bit = isr & (~isr + 1'b1);
  assign isr_set = (take & ~aeoi) ? req_bit : '0;
  assign isr_clr = eoi_sp ? (LINES'(1) << bus_wdata[IW-1:0]) : (eoi_ns ? isr_bit : '0);
  assign bus_rdata = bus_a0 ? imr : (rsel ? isr : irr);

  always_comb begin
    allowed[0] = ~isr[0];
    for (int i = 1; i < LINES; i++) allowed[i] = allowed[i-1] & ~isr[i];
  end

  always_comb begin
    req_idx = '0;
    for (int i = 0; i < LINES; i++) if (req_bit[i]) req_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= '0;
      edge_irr <= '0;
      isr      <= '0;
      vector   <= '0;
    end else begin
      irq_q    <= irq_in;
      edge_irr <= (edge_irr | (irq_in & ~irq_q)) & irq_in & ~(take ? req_bit : '0);
      isr      <= (isr & ~isr_clr) | isr_set;
      if (ack) vector <= {base, (take ? req_idx : IW'(LINES - 1))};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RUN;
      imr       <= '1;
      base      <= '0;
      need_mode <= 1'b0;
      aeoi      <= 1'b0;
      rsel      <= 1'b0;
    end else if (init_wr) begin
      st        <= W_BASE;
      imr       <= '0;
      rsel      <= 1'b0;
      aeoi      <= 1'b0;
      need_mode <= bus_wdata[0];
    end else begin
      if (rd_sel) rsel <= bus_wdata[0];
      if (dat_wr) begin
        unique case (st)
          W_BASE: begin base <= bus_wdata[DW-1:IW]; st <= W_CASC; end
          W_CASC: st <= need_mode ? W_MODE : RUN;
          W_MODE: begin aeoi <= bus_wdata[1]; st <= RUN; end
          default: imr <= bus_wdata;
        endcase
      end
    end
  end
endmodule

module irq_ctrl8_chk #(
  parameter int DW = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_a0,
  input logic [DW-1:0] bus_wdata,
  input logic          ack,
  input logic          int_out,
  input logic [DW-1:0] vector,
  input logic [DW-1:0] isr,
  input logic [DW-1:0] irr,
  input logic [DW-1:0] imr,
  input logic [DW-IW-1:0] base,
  input logic          aeoi,
  input logic          run
);
  // R3
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vector[DW-1:IW] == $past(base));
  // R11
  spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !int_out |=> vector[IW-1:0] == '1);
  // R11
  spur_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !int_out && !bus_wr |=> isr == $past(isr));
  // R9
  aeoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && aeoi && !bus_wr |=> isr == $past(isr));
  // R4
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && int_out && !aeoi && !bus_wr |=> $countones(isr) == $past($countones(isr)) + 1);
  // R7
  seoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && bus_wr && !bus_a0 && bus_wdata[7:3] == 5'b01100 && !ack |=> !isr[$past(bus_wdata[IW-1:0])]);
  // R6
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> |(irr & ~imr));
  // R2
  icw1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_a0 && bus_wdata[4] |=> imr == '0 && !run);
endmodule

bind irq_ctrl8 irq_ctrl8_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_a0(bus_a0), .bus_wdata(bus_wdata),
  .ack(ack), .int_out(int_out), .vector(vector), .isr(isr), .irr(irr), .imr(imr),
  .base(base), .aeoi(aeoi), .run(run)
);

// File: tb/test_irq_ctrl8.sv
`timescale 1ns/1ps
module test_irq_ctrl8;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_a0 = 1'b0, ack = 1'b0;
  logic [7:0] bus_wdata = '0, irq_in = '0, trig_level = '0;
  logic [7:0] bus_rdata, vector;
  logic int_out;
  int total = 0, failed = 0;

  irq_ctrl8 i_irq_ctrl8 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_a0(bus_a0), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_in(irq_in), .trig_level(trig_level), .ack(ack),
    .int_out(int_out), .vector(vector)
  );

  always #2.5 clk = ~clk;

  // {request pattern, mask, expected int_out, expected vector}
  localparam logic [24:0] TBL [7] = '{
    {8'h01, 8'h00, 1'b1, 8'h40},
    {8'h84, 8'h00, 1'b1, 8'h42},
    {8'h80, 8'h00, 1'b1, 8'h47},
    {8'h06, 8'h02, 1'b1, 8'h42},
    {8'h10, 8'h10, 1'b0, 8'h47},
    {8'hF0, 8'h30, 1'b1, 8'h46},
    {8'h00, 8'h00, 1'b0, 8'h47}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic a0, logic [7:0] d);
    bus_wr = 1'b1; bus_a0 = a0; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic a0, output logic [7:0] d);
    bus_a0 = a0; #0.5; d = bus_rdata;
  endtask

  task automatic pulse_ack;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic set_irq(logic [7:0] v);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    total++; failed++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 int", {7'b0, int_out}, 8'h00);
    rd(1'b1, r); check("R1 imr", r, 8'hFF);
    rd(1'b0, r); check("R1 irr", r, 8'h00);
    check("R1 vector", vector, 8'h00);

    // R2 setup with mode byte, normal EOI
    wr(1'b0, 8'h11);
    rd(1'b1, r); check("R2 imr cleared", r, 8'h00);
    wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    wr(1'b1, 8'hA5);
    rd(1'b1, r); check("R12 imr readback", r, 8'hA5);
    wr(1'b1, 8'h00);

    // table walk: R3 R4 R6 R11
    for (int k = 0; k < 7; k++) begin
      wr(1'b1, TBL[k][16:9]);
      set_irq(TBL[k][24:17]);
      check("R6 int_out", {7'b0, int_out}, {7'b0, TBL[k][8]});
      pulse_ack();
      check("R3 vector", vector, TBL[k][7:0]);
      set_irq(8'h00);
      wr(1'b0, 8'h20);
    end
    wr(1'b1, 8'h00);

    // R6 masked line still recorded
    wr(1'b1, 8'h08);
    set_irq(8'h08);
    rd(1'b0, r); check("R6 irr recorded", r, 8'h08);
    check("R6 int blocked", {7'b0, int_out}, 8'h00);
    set_irq(8'h00);
    wr(1'b1, 8'h00);

    // R4 in-service blocking
    set_irq(8'h08);
    pulse_ack(); check("R4 vec line3", vector, 8'h43);
    set_irq(8'h28);
    check("R4 lower blocked", {7'b0, int_out}, 8'h00);
    set_irq(8'h2A);
    check("R4 higher passes", {7'b0, int_out}, 8'h01);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R10 isr read", r, 8'h08);
    pulse_ack(); check("R4 vec line1", vector, 8'h41);
    rd(1'b0, r); check("R10 isr persists", r, 8'h0A);
    wr(1'b0, 8'h63);
    rd(1'b0, r); check("R7 specific eoi", r, 8'h02);
    wr(1'b0, 8'h20);
    rd(1'b0, r); check("R8 nonspecific eoi", r, 8'h00);
    check("R4 line5 now passes", {7'b0, int_out}, 8'h01);
    wr(1'b0, 8'h0A);
    rd(1'b0, r); check("R5 R10 irr edge latches", r, 8'h20);
    set_irq(8'h00);

    // R8 clears only lowest-numbered bit
    set_irq(8'h40); pulse_ack(); set_irq(8'h00);
    set_irq(8'h04); pulse_ack(); set_irq(8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R8 two in service", r, 8'h44);
    wr(1'b0, 8'h20);
    rd(1'b0, r); check("R8 lowest cleared", r, 8'h40);
    wr(1'b0, 8'h20);

    // R5 level mode
    trig_level = 8'h40;
    irq_in = 8'h40; #0.5;
    wr(1'b0, 8'h0A);
    rd(1'b0, r); check("R5 level irr", r, 8'h40);
    pulse_ack(); check("R5 level vec", vector, 8'h46);
    rd(1'b0, r); check("R5 level irr holds", r, 8'h40);
    set_irq(8'h00);
    rd(1'b0, r); check("R5 level irr drops", r, 8'h00);
    wr(1'b0, 8'h20);
    trig_level = 8'h00;

    // R11 request vanishes before acknowledge
    set_irq(8'h04);
    set_irq(8'h00);
    check("R5 edge drop", {7'b0, int_out}, 8'h00);
    pulse_ack(); check("R11 spurious vec", vector, 8'h47);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R11 isr empty", r, 8'h00);

    // R9 automatic EOI
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h80); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    set_irq(8'h10);
    pulse_ack(); check("R9 vec", vector, 8'h84);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R9 isr untouched", r, 8'h00);
    set_irq(8'h00);

    // R2 setup without mode byte
    wr(1'b0, 8'h10);
    rd(1'b0, r); check("R2 select reset to irr", r, 8'h00);
    wr(1'b1, 8'h08); wr(1'b1, 8'h00);
    wr(1'b1, 8'h5A);
    rd(1'b1, r); check("R2 R12 mask after short setup", r, 8'h5A);
    wr(1'b1, 8'h00);
    set_irq(8'h01);
    pulse_ack(); check("R3 vec new base", vector, 8'h08);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); check("R9 mode off", r, 8'h01);
    set_irq(8'h00);
    finish_run();
  end
endmodule